// File: doc/BRIEF.md
# SPI Register File Slave

This block is a serial slave that lets a host reach a bank of 25-bit registers through fixed 32-bit full-duplex frames. SPI mode 0 is used: the clock idles low, the host drives MOSI while the clock is low, and both ends sample on the rising edge. The first bit of a frame is the operation bit. The next five bits select one of 32 registers. One spare bit follows, and the final 25 bits carry the data.

A write frame updates the selected register once the last bit has arrived. The update is handed to the system clock domain through a toggle and a two-flop synchroniser. Side logic then sees a one-cycle strobe, one bit per register, together with the address and the new value. A read frame needs no second frame. The slave loads the selected register once the header has been shifted in, and sends it back on MISO in the data bits of the same frame. A parameter sets whether chip select is active low (the default) or active high. All register contents are visible in parallel on a flat output bus.

Top module: `spi_regfile`

## Requirements
- R1: After reset every register reads zero, no write strobe is raised, and MISO is 0.
- R2: A frame whose bit 31 is 1 is a write. Bits 30:26 give the register address and bits 24:0 the new value. The addressed register takes that value, and the value appears in `reg_q` at bit offset address*25.
- R3: Bit 25 of a frame has no effect. A write with bit 25 set stores only bits 24:0.
- R4: A frame whose bit 31 is 0 is a read. In that same frame MISO returns zeros for bits 31:25 and the addressed register's contents in bits 24:0. A read changes no register and raises no strobe.
- R5: During a write frame MISO stays 0 for all 32 bits.
- R6: If chip select goes inactive before the 32nd rising SCLK edge, the frame is dropped. No register changes and no strobe is raised, even when only one bit is missing.
- R7: Each completed write raises `wr_stb` for exactly one system clock cycle. The strobe has only bit <address> set. `wr_addr` and `wr_data` hold the address and value in that cycle, and `reg_q` already shows the new value in that cycle.
- R8: With `CS_ACTIVE_HIGH`=1, chip select is active when high. While chip select is inactive the slave ignores SCLK and MOSI, and MISO is 0.
- R9: A write changes only the addressed register. `reg_q` changes in no cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idles low |
| spi_cs | input | 1 | Chip select; its active level is set by CS_ACTIVE_HIGH |
| spi_mosi | input | 1 | Serial data from the host, MSB first |
| spi_miso | output | 1 | Serial data to the host, changes on falling SCLK |
| wr_stb | output | 32 | One-cycle write strobe, one bit per register |
| wr_addr | output | 5 | Address of the register just written |
| wr_data | output | 25 | Value just written |
| reg_q | output | 800 | All register contents, register n at bits n*25 +: 25 |

## Verification
The assertions assume a single host. They also assume that consecutive write frames are spaced by at least a few system clocks, so each toggle handshake settles before the next frame's final bit. They further assume that SCLK only moves while chip select is active. The stimulus keeps within this: it holds SCLK low around every chip-select change, and waits ten system clocks after each frame before checking or starting the next. It drives the active-high instance only while the active-low instance is deselected, and the reverse.

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 25,
  parameter bit CS_ACTIVE_HIGH = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     spi_sclk,
  input  logic                     spi_cs,
  input  logic                     spi_mosi,
  output logic                     spi_miso,
  output logic [(1<<ADDR_W)-1:0]   wr_stb,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic [DATA_W-1:0]        wr_data,
  output logic [(1<<ADDR_W)*DATA_W-1:0] reg_q
);
  localparam int NREG    = 1 << ADDR_W;
  localparam int HDR     = 1 + ADDR_W;
  localparam int FRAME_W = HDR + 1 + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic              cs_act, frm_rst_n;
  logic [CNT_W-1:0]  cnt;
  logic [FRAME_W-2:0] sh;
  logic [DATA_W:0]   tx;
  logic              wtog;
  logic [ADDR_W+DATA_W-1:0] wframe;
  logic              s1, s2, s3;
  logic              wpulse;
  logic [DATA_W-1:0] regs [NREG];

  assign cs_act    = CS_ACTIVE_HIGH ? spi_cs : ~spi_cs;
  assign frm_rst_n = rst_n & cs_act;
  assign spi_miso  = cs_act & tx[DATA_W];
  assign wpulse    = s2 ^ s3;

  always_ff @(posedge spi_sclk or negedge frm_rst_n) begin
    if (!frm_rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else begin
      sh <= {sh[FRAME_W-3:0], spi_mosi};
      if (cnt != CNT_W'(FRAME_W)) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge spi_sclk or negedge rst_n) begin
    if (!rst_n) begin
      wtog   <= 1'b0;
      wframe <= '0;
    end else if (cs_act && cnt == CNT_W'(FRAME_W-1) && sh[FRAME_W-2]) begin
      wtog   <= ~wtog;
      wframe <= {sh[FRAME_W-3 -: ADDR_W], sh[DATA_W-2:0], spi_mosi};
    end
  end

  always_ff @(negedge spi_sclk or negedge frm_rst_n) begin
    if (!frm_rst_n)
      tx <= '0;
    else if (cnt == CNT_W'(HDR))
      tx <= sh[HDR-1] ? '0 : {1'b0, regs[sh[ADDR_W-1:0]]};
    else if (cnt > CNT_W'(HDR))
      tx <= {tx[DATA_W-1:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {wtog, s1, s2};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      wr_stb  <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= '0;
      if (wpulse) begin
        regs[wframe[ADDR_W+DATA_W-1 -: ADDR_W]] <= wframe[DATA_W-1:0];
        wr_stb  <= NREG'(1) << wframe[ADDR_W+DATA_W-1 -: ADDR_W];
        wr_addr <= wframe[ADDR_W+DATA_W-1 -: ADDR_W];
        wr_data <= wframe[DATA_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign reg_q[g*DATA_W +: DATA_W] = regs[g];
  end
endmodule

module spi_regfile_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 25,
  parameter bit CS_ACTIVE_HIGH = 1'b0
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     spi_cs,
  input logic                     spi_miso,
  input logic [(1<<ADDR_W)-1:0]   wr_stb,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic [DATA_W-1:0]        wr_data,
  input logic [(1<<ADDR_W)*DATA_W-1:0] reg_q
);
  logic cs_on;
  assign cs_on = CS_ACTIVE_HIGH ? spi_cs : ~spi_cs;

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb)) else $error("strobe not one-hot"); // R7
  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb != '0) |=> (wr_stb == '0)) else $error("strobe too long"); // R7
  AST_STB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb != '0) |-> (wr_stb[wr_addr] && reg_q[wr_addr*DATA_W +: DATA_W] == wr_data))
    else $error("strobe and register disagree"); // R2
  AST_NO_SILENT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb == '0) |-> $stable(reg_q)) else $error("register changed without strobe"); // R9
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_on |-> !spi_miso) else $error("miso driven while deselected"); // R8
endmodule

bind spi_regfile spi_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_ACTIVE_HIGH(CS_ACTIVE_HIGH)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs(spi_cs), .spi_miso(spi_miso),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .reg_q(reg_q)
);

// File: tb/sim_spi_regfile.sv
`timescale 1ns/1ps
module sim_spi_regfile;
  localparam int HALF = 20;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, mosi = 0, cs0 = 1, cs1 = 0;
  logic miso0, miso1;
  logic [31:0] stb0, stb1;
  logic [4:0] wa0, wa1;
  logic [24:0] wd0, wd1;
  logic [799:0] q0, q1;

  always #4 clk = ~clk;

  spi_regfile u0 (.clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs(cs0), .spi_mosi(mosi),
    .spi_miso(miso0), .wr_stb(stb0), .wr_addr(wa0), .wr_data(wd0), .reg_q(q0));
  spi_regfile #(.CS_ACTIVE_HIGH(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs(cs1),
    .spi_mosi(mosi), .spi_miso(miso1), .wr_stb(stb1), .wr_addr(wa1), .wr_data(wd1), .reg_q(q1));

  int checks = 0, errors = 0, n0 = 0, n1 = 0;
  logic [31:0] ls0 = 0, ls1 = 0;
  logic [4:0] la0 = 0;
  logic [24:0] ld0 = 0;
  logic [24:0] model [32];
  bit done = 0;

  always @(posedge clk) begin
    if (stb0 != 0) begin n0 <= n0 + 1; ls0 <= stb0; la0 <= wa0; ld0 <= wd0; end
    if (stb1 != 0) begin n1 <= n1 + 1; ls1 <= stb1; end
  end

  function automatic logic [31:0] fw(input logic [4:0] a, input logic b25, input logic [24:0] d);
    return {1'b1, a, b25, d};
  endfunction
  function automatic logic [31:0] fr(input logic [4:0] a, input logic [24:0] d);
    return {1'b0, a, 1'b0, d};
  endfunction

  localparam logic [63:0] VEC [9] = '{
    {fw(5'd3, 1'b0, 25'h0ABCDEF), 32'h0},
    {fw(5'd31, 1'b1, 25'h1FFFFFF), 32'h0},     // R3: bit 25 set on input
    {fw(5'd0, 1'b0, 25'h0000001), 32'h0},
    {fr(5'd3, 25'h1234567), {7'd0, 25'h0ABCDEF}},
    {fr(5'd31, 25'h0), {7'd0, 25'h1FFFFFF}},
    {fr(5'd0, 25'h1FFFFFF), {7'd0, 25'h0000001}},
    {fr(5'd5, 25'h0), 32'h0},
    {fw(5'd3, 1'b0, 25'h1555555), 32'h0},
    {fr(5'd3, 25'h0AAAAAA), {7'd0, 25'h1555555}}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic xfer(input bit sel, input logic [31:0] tx, input int nbits, output logic [31:0] rx);
    rx = 0;
    if (sel) cs1 = 1; else cs0 = 0;
    #HALF;
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[31-i];
      #HALF;
      rx[31-i] = sel ? miso1 : miso0;
      sclk = 1;
      #HALF;
      sclk = 0;
    end
    #HALF;
    cs0 = 1; cs1 = 0; mosi = 0;
    repeat (10) @(posedge clk);
    #1;
  endtask

  initial begin
    logic [31:0] rx, tx, ex;
    int nb, nb1;
    bit ok;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 regs zero", {31'd0, q0 == '0}, 32'd1);
    chk("R1 strobe idle", stb0, 32'd0);
    chk("R1 miso idle", {31'd0, miso0}, 32'd0);

    for (int i = 0; i < 9; i++) begin
      tx = VEC[i][63:32];
      ex = VEC[i][31:0];
      nb = n0;
      xfer(0, tx, 32, rx);
      if (tx[31]) begin
        model[tx[30:26]] = tx[24:0];
        chk("R5 write returns zeros", rx, ex);
        chk("R7 one strobe cycle", n0, nb + 1);
        chk("R7 strobe bit", ls0, 32'd1 << tx[30:26]);
        chk("R7 strobe addr", {27'd0, la0}, {27'd0, tx[30:26]});
        chk("R2 strobe data", {7'd0, ld0}, {7'd0, tx[24:0]});
        chk("R2 reg updated", {7'd0, q0[tx[30:26]*25 +: 25]}, {7'd0, tx[24:0]});
      end else begin
        chk("R4 read data same frame", rx, ex);
        chk("R4 read raises no strobe", n0, nb);
      end
    end
    ok = 1;
    for (int a = 0; a < 32; a++) if (q0[a*25 +: 25] !== model[a]) ok = 0;
    chk("R9 only addressed regs changed", {31'd0, ok}, 32'd1);
    chk("R8 deselected instance ignored traffic", n1, 0);

    nb = n0;
    xfer(0, fw(5'd9, 1'b1, 25'h0), 32, rx);
    xfer(0, fr(5'd9, 25'h0), 32, rx);
    chk("R3 bit 25 not stored", rx, 32'h0);
    chk("R3 strobe for write", n0, nb + 1);

    nb = n0;
    xfer(0, fw(5'd7, 1'b0, 25'h1111111), 20, rx);
    chk("R6 abort at 20 bits no strobe", n0, nb);
    xfer(0, fw(5'd7, 1'b0, 25'h1111111), 31, rx);
    chk("R6 abort at 31 bits no strobe", n0, nb);
    chk("R6 reg untouched", {7'd0, q0[7*25 +: 25]}, 32'd0);
    xfer(0, fr(5'd7, 25'h0), 32, rx);
    chk("R6 read after abort", rx, 32'd0);

    nb = n0; nb1 = n1;
    xfer(1, fw(5'd12, 1'b0, 25'h0C0FFEE), 32, rx);
    chk("R8 active-high write strobe", n1, nb1 + 1);
    chk("R8 active-high strobe bit", ls1, 32'd1 << 12);
    chk("R8 active-high reg", {7'd0, q1[12*25 +: 25]}, {7'd0, 25'h0C0FFEE});
    xfer(1, fr(5'd12, 25'h0), 32, rx);
    chk("R8 active-high read", rx, {7'd0, 25'h0C0FFEE});
    chk("R8 active-low instance ignored", n0, nb);
    chk("R8 active-low reg 12 untouched", {7'd0, q0[12*25 +: 25]}, 32'd0);
    chk("R8 miso idle", {30'd0, miso0, miso1}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule